// File: doc/BRIEF.md
# Audio Bit and Word Clock Generator

This block is the clock-master side of a serial audio port. From a single fast reference clock it produces the bit clock that shifts data on the bus, the word clock that marks frames, and a one-cycle frame-start strobe for the local serializer. The reference clock runs at 512 times the sample rate, so one frame lasts exactly `REF_CYCLES` (512 by default) reference cycles.

Three settings can be changed. The data-width code selects 16, 20, 24 or 32 bits per channel, with two channels per frame. The transfer style chooses between emitting only the bit clocks the data needs and emitting a fixed 256 per frame. The word-clock shape is either a one-bit-wide pulse or a half-frame square wave. Bit-clock rates that do not divide the reference evenly are produced by a phase accumulator. It spreads the edges over the frame so that each frame holds the exact edge count, although individual high and low phases differ by one reference cycle.

The settings are sampled only at frame boundaries. A power-down input releases the bit-clock and word-clock pins to high impedance and parks the generator. When power-down is released, the next frame starts at once.

Top module: `aud_clkgen`

## Requirements
- R1: With `fixed_i`=0, every frame holds exactly twice the data width of bit-clock rising edges, where `word_len_i` 0, 1, 2, 3 means 16, 20, 24, 32 bits (so 32, 40, 48 and 64 rising edges).
- R2: For the 16-bit and 32-bit widths with `fixed_i`=0, every bit-clock high and low phase lasts exactly 8 or exactly 4 reference cycles respectively.
- R3: For the 20-bit and 24-bit widths with `fixed_i`=0, each high or low phase lasts 6 or 7 (20-bit) or 5 or 6 (24-bit) reference cycles, and the frame still spans exactly 512 reference cycles with the exact edge count.
- R4: With `fixed_i`=1, every frame holds 256 bit-clock rising edges whatever `word_len_i` is, and the bit clock changes level on every reference cycle.
- R5: With `square_i`=1, the word clock is high for the first 256 reference cycles of each frame, starting with the first bit-clock rise, and low for the remaining 256.
- R6: With `square_i`=0, the word clock rises together with the first bit-clock rise of the frame and stays high for exactly one bit-clock period, up to the next rising edge.
- R7: `frame_start_o` is high for one reference cycle per frame, in the cycle in which the first bit-clock rise of the frame appears, and recurs every 512 reference cycles.
- R8: While `pwr_dn_i`=1, `bclk_o` and `wclk_o` are not driven. After `pwr_dn_i` falls, `frame_start_o` and the first bit-clock rise appear on the second rising clock edge.
- R9: A settings change made in the middle of a frame leaves that frame unchanged and applies from the next frame.
- R10: During reset, `bclk_o`, `wclk_o` and `frame_start_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 512 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down: release outputs and park the generator |
| word_len_i | input | 2 | Data width code: 0=16, 1=20, 2=24, 3=32 bits |
| fixed_i | input | 1 | 1 = 256 bit clocks per frame, 0 = only the needed bit clocks |
| square_i | input | 1 | 1 = square word clock, 0 = pulse word clock |
| bclk_o | inout | 1 | Bit clock pin; only ever driven by the block, high impedance while powered down |
| wclk_o | inout | 1 | Word clock pin; only ever driven by the block, high impedance while powered down |
| frame_start_o | output | 1 | One-cycle strobe at the first bit-clock rise of a frame |

## Verification
The bit clock, word clock and strobe are registered. Their values for frame cycle k appear one edge after the frame counter holds k, so the strobe, the first bit-clock rise and the word-clock rise all fall on the same clock edge, which is the second edge after a boundary or after the release of power-down. High impedance follows power-down without any clock edge. The bench drives inputs and samples outputs on the falling clock edge. It aligns each measurement to the sampled strobe and then classifies exactly 512 consecutive samples as one frame. A settings change takes effect only at the boundary edge, so the bench drives the new settings anywhere in a frame and measures the frame after the next strobe.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    // Per-channel data width selection.
    typedef enum logic [1:0] {
        LEN_16 = 2'd0,
        LEN_20 = 2'd1,
        LEN_24 = 2'd2,
        LEN_32 = 2'd3
    } word_len_e;

    // Settings that are held for a whole frame.
    typedef struct packed {
        word_len_e len;
        logic      fixed;
        logic      square;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{len: LEN_16, fixed: 1'b0, square: 1'b0};

    function automatic int unsigned data_bits(word_len_e len);
        case (len)
            LEN_16:  return 16;
            LEN_20:  return 20;
            LEN_24:  return 24;
            default: return 32;
        endcase
    endfunction

    // Bit-clock level changes in one frame: two per bit clock, two channels
    // per frame.
    function automatic int unsigned edges_per_frame(clk_cfg_t cfg,
                                                    int unsigned fixed_clocks);
        if (cfg.fixed) begin
            return 2 * fixed_clocks;
        end
        return 4 * data_bits(cfg.len);
    endfunction

endpackage

// File: rtl/aud_frame_timer.sv
module aud_frame_timer
    import aud_clkgen_pkg::*;
#(
    parameter int unsigned REF_CYCLES   = 512,
    parameter int unsigned FIXED_CLOCKS = 256,
    parameter int unsigned CNT_W        = 9,
    parameter int unsigned ACC_W        = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwr_dn_i,
    input  clk_cfg_t         cfg_i,
    output logic             first_o,
    output logic             last_o,
    output logic             first_half_o,
    output logic             square_o,
    output logic [ACC_W-1:0] step_cur_o,
    output logic [ACC_W-1:0] step_next_o,
    output logic             strobe_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(REF_CYCLES / 2);

    typedef struct packed {
        clk_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } tmr_state_t;

    localparam tmr_state_t TMR_IDLE = '{cfg: CFG_RESET, cnt: CNT_LAST, strobe: 1'b0};

    tmr_state_t state_d, state_q;
    logic       at_first, at_last;

    always_comb begin
        at_first = (state_q.cnt == '0);
        at_last  = (state_q.cnt == CNT_LAST);
        state_d  = state_q;

        state_d.strobe = at_first;
        if (at_last) begin
            state_d.cnt = '0;
            state_d.cfg = cfg_i;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end

        if (pwr_dn_i) begin
            state_d = TMR_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign first_o      = at_first;
    assign last_o       = at_last;
    assign first_half_o = (state_q.cnt < CNT_HALF);
    assign square_o     = state_q.cfg.square;
    assign step_cur_o   = ACC_W'(edges_per_frame(state_q.cfg, FIXED_CLOCKS));
    assign step_next_o  = ACC_W'(edges_per_frame(cfg_i, FIXED_CLOCKS));
    assign strobe_o     = state_q.strobe;

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!at_last && !pwr_dn_i) |=> $stable(state_q.cfg)); // R9

    AST_PD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_dn_i |=> (last_o && !strobe_o)); // R8

endmodule

// File: rtl/aud_bclk_accum.sv
module aud_bclk_accum #(
    parameter int unsigned REF_CYCLES = 512,
    parameter int unsigned ACC_W      = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwr_dn_i,
    input  logic             first_i,
    input  logic             last_i,
    input  logic [ACC_W-1:0] step_cur_i,
    input  logic [ACC_W-1:0] step_next_i,
    output logic             bclk_o,
    output logic [ACC_W-1:0] edges_next_o
);

    localparam logic [ACC_W-1:0] REF_VAL = ACC_W'(REF_CYCLES);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] edges;
        logic             bclk;
        logic             full;
    } acc_state_t;

    localparam acc_state_t ACC_IDLE = '{acc: '0, edges: '0, bclk: 1'b0, full: 1'b0};

    acc_state_t       state_d, state_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        state_d = state_q;
        sum     = state_q.acc + step_cur_i;
        wrap    = (sum >= REF_VAL);

        // One level change per accumulator wrap spreads the edges evenly
        // over the frame, to within one reference cycle.
        state_d.bclk  = state_q.bclk ^ wrap;
        state_d.acc   = wrap ? (sum - REF_VAL) : sum;
        state_d.edges = (first_i ? '0 : state_q.edges) + ACC_W'(wrap);
        state_d.full  = state_q.full | first_i;

        // Preload so that the first cycle of the next frame wraps at once.
        if (last_i) begin
            state_d.acc = REF_VAL - step_next_i;
        end

        if (pwr_dn_i) begin
            state_d = ACC_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign bclk_o       = state_q.bclk;
    assign edges_next_o = state_d.edges;

    AST_EDGES_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.full && last_i && !pwr_dn_i) |-> (state_d.edges == step_cur_i)); // R1

    AST_BCLK_LOW_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_i |-> !state_q.bclk); // R3

endmodule

// File: rtl/aud_wclk_shape.sv
module aud_wclk_shape #(
    parameter int unsigned ACC_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwr_dn_i,
    input  logic             square_i,
    input  logic             first_i,
    input  logic             first_half_i,
    input  logic [ACC_W-1:0] edges_next_i,
    output logic             wclk_o
);

    typedef struct packed {
        logic wclk;
    } wclk_state_t;

    localparam wclk_state_t WCLK_IDLE = '{wclk: 1'b0};

    wclk_state_t state_d, state_q;
    logic        pulse_win;

    always_comb begin
        state_d = state_q;
        // Pulse covers the first rising and first falling bit-clock edge.
        pulse_win = (edges_next_i == ACC_W'(1)) || (edges_next_i == ACC_W'(2));
        state_d.wclk = square_i ? first_half_i : pulse_win;
        if (pwr_dn_i) begin
            state_d = WCLK_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WCLK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign wclk_o = state_q.wclk;

    AST_WCLK_LOW_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_i |-> !state_q.wclk); // R5

    AST_WCLK_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (first_i && !pwr_dn_i) |=> state_q.wclk); // R6

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aud_clkgen_pkg::*;
#(
    parameter int unsigned REF_CYCLES   = 512,
    parameter int unsigned FIXED_CLOCKS = 256
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_dn_i,
    input  logic [1:0] word_len_i,
    input  logic       fixed_i,
    input  logic       square_i,
    inout  wire        bclk_o,
    inout  wire        wclk_o,
    output logic       frame_start_o
);

    localparam int unsigned CNT_W = $clog2(REF_CYCLES);
    localparam int unsigned ACC_W = CNT_W + 1;

    clk_cfg_t         cfg_in;
    logic             first, last, first_half, square_cur;
    logic [ACC_W-1:0] step_cur, step_next, edges_next;
    logic             bclk_int, wclk_int, strobe;

    assign cfg_in = '{len: word_len_e'(word_len_i), fixed: fixed_i, square: square_i};

    aud_frame_timer #(
        .REF_CYCLES  (REF_CYCLES),
        .FIXED_CLOCKS(FIXED_CLOCKS),
        .CNT_W       (CNT_W),
        .ACC_W       (ACC_W)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pwr_dn_i    (pwr_dn_i),
        .cfg_i       (cfg_in),
        .first_o     (first),
        .last_o      (last),
        .first_half_o(first_half),
        .square_o    (square_cur),
        .step_cur_o  (step_cur),
        .step_next_o (step_next),
        .strobe_o    (strobe)
    );

    aud_bclk_accum #(
        .REF_CYCLES(REF_CYCLES),
        .ACC_W     (ACC_W)
    ) u_accum (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pwr_dn_i    (pwr_dn_i),
        .first_i     (first),
        .last_i      (last),
        .step_cur_i  (step_cur),
        .step_next_i (step_next),
        .bclk_o      (bclk_int),
        .edges_next_o(edges_next)
    );

    aud_wclk_shape #(
        .ACC_W(ACC_W)
    ) u_wclk (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pwr_dn_i    (pwr_dn_i),
        .square_i    (square_cur),
        .first_i     (first),
        .first_half_i(first_half),
        .edges_next_i(edges_next),
        .wclk_o      (wclk_int)
    );

    assign bclk_o        = pwr_dn_i ? 1'bz : bclk_int;
    assign wclk_o        = pwr_dn_i ? 1'bz : wclk_int;
    assign frame_start_o = strobe;

    AST_STROBE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe |-> (bclk_int && !$past(bclk_int))); // R7

endmodule

// File: tb/aud_clkgen_test.sv
module aud_clkgen_test;

    localparam int FRAME = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [1:0] len = 2'd0;
    logic       fixed = 1'b0;
    logic       square = 1'b0;
    wire        bclk_w;
    wire        wclk_w;
    logic       fs;

    int checks = 0;
    int errors = 0;

    pullup (bclk_w);
    pullup (wclk_w);

    always #10 clk = ~clk;

    aud_clkgen uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pwr_dn_i     (pwr_dn),
        .word_len_i   (len),
        .fixed_i      (fixed),
        .square_i     (square),
        .bclk_o       (bclk_w),
        .wclk_o       (wclk_w),
        .frame_start_o(fs)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fs();
        bit found = 1'b0;
        for (int i = 0; i < 2 * FRAME; i++) begin
            @(negedge clk);
            if (fs) begin
                found = 1'b1;
                break;
            end
        end
        chk(found, "R7", "strobe seen", int'(found), 1);
    endtask

    // Classifies 512 samples starting at a strobe sample.
    task automatic measure(input bit aligned, input int chg_idx, input logic [1:0] chg_len,
                           output int rises, output int rmin, output int rmax,
                           output int whigh, output int period1, output bit wcontig,
                           output int fsn, output bit next_fs);
        bit b, w, prev, wlow;
        int run;
        if (!aligned) wait_fs();
        rises = 0; rmin = FRAME; rmax = 0; whigh = 0; period1 = 0;
        wcontig = 1'b1; fsn = 0; prev = 1'b0; wlow = 1'b0; run = 0;
        for (int i = 0; i < FRAME; i++) begin
            if (i > 0) @(negedge clk);
            b = bclk_w;
            w = wclk_w;
            if (b && !prev) begin
                rises++;
                if (rises == 2) period1 = i;
            end
            if (i > 0 && b != prev) begin
                if (run < rmin) rmin = run;
                if (run > rmax) rmax = run;
                run = 1;
            end else begin
                run++;
            end
            if (w) begin
                whigh++;
                if (wlow) wcontig = 1'b0;
            end else begin
                wlow = 1'b1;
            end
            if (fs) fsn++;
            prev = b;
            if (i == chg_idx) len = chg_len;
        end
        if (run < rmin) rmin = run;
        if (run > rmax) rmax = run;
        @(negedge clk);
        next_fs = fs;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(bclk_w == 1'b0, "R10", "bclk in reset", int'(bclk_w), 0);
        chk(wclk_w == 1'b0, "R10", "wclk in reset", int'(wclk_w), 0);
        chk(fs == 1'b0, "R10", "strobe in reset", int'(fs), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_mode(input logic [1:0] l, input bit fx, input bit sq,
                             input int exp_rises, input int exp_min, input int exp_max,
                             input string req_cnt, input string req_ph);
        int rises, rmin, rmax, whigh, period1, fsn;
        bit wcontig, next_fs;
        @(negedge clk);
        len = l; fixed = fx; square = sq;
        wait_fs();
        measure(1'b1, -1, l, rises, rmin, rmax, whigh, period1, wcontig, fsn, next_fs);
        chk(rises == exp_rises, req_cnt, "rises per frame", rises, exp_rises);
        chk(rmin == exp_min, req_ph, "shortest phase", rmin, exp_min);
        chk(rmax == exp_max, req_ph, "longest phase", rmax, exp_max);
        if (sq) begin
            chk(whigh == FRAME / 2, "R5", "square wclk high cycles", whigh, FRAME / 2);
            chk(wcontig, "R5", "square wclk from frame start", int'(wcontig), 1);
        end else begin
            chk(whigh == period1, "R6", "pulse wclk width vs bit period", whigh, period1);
            chk(wcontig, "R6", "pulse wclk from frame start", int'(wcontig), 1);
        end
        chk(fsn == 1, "R7", "strobes per frame", fsn, 1);
        chk(next_fs, "R7", "strobe after 512 cycles", int'(next_fs), 1);
    endtask

    task automatic test_midframe_change();
        int rises, rmin, rmax, whigh, period1, fsn;
        bit wcontig, next_fs;
        @(negedge clk);
        len = 2'd0; fixed = 1'b0; square = 1'b0;
        wait_fs();
        wait_fs();
        // R9: switch to 32-bit at sample 100 of a 16-bit frame.
        measure(1'b1, 100, 2'd3, rises, rmin, rmax, whigh, period1, wcontig, fsn, next_fs);
        chk(rises == 32, "R9", "frame with mid change keeps old width", rises, 32);
        chk(next_fs, "R9", "boundary kept", int'(next_fs), 1);
        measure(1'b1, -1, 2'd3, rises, rmin, rmax, whigh, period1, wcontig, fsn, next_fs);
        chk(rises == 64, "R9", "next frame uses new width", rises, 64);
    endtask

    task automatic test_power_down();
        @(negedge clk);
        pwr_dn = 1'b1;
        #1;
        chk(bclk_w == 1'b1, "R8", "bclk released (pulled up)", int'(bclk_w), 1);
        chk(wclk_w == 1'b1, "R8", "wclk released (pulled up)", int'(wclk_w), 1);
        repeat (5) @(negedge clk);
        chk(bclk_w == 1'b1, "R8", "bclk stays released", int'(bclk_w), 1);
        chk(fs == 1'b0, "R8", "no strobe while down", int'(fs), 0);
        pwr_dn = 1'b0;
        #1;
        chk(bclk_w == 1'b0, "R8", "bclk driven low after release", int'(bclk_w), 0);
        @(negedge clk);
        chk(fs == 1'b0, "R8", "no strobe one edge after release", int'(fs), 0);
        @(negedge clk);
        chk(fs == 1'b1, "R8", "strobe two edges after release", int'(fs), 1);
        chk(bclk_w == 1'b1, "R8", "first bclk rise two edges after release", int'(bclk_w), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_mode(2'd0, 1'b0, 1'b0, 32, 8, 8, "R1", "R2");
        test_mode(2'd3, 1'b0, 1'b1, 64, 4, 4, "R1", "R2");
        test_mode(2'd1, 1'b0, 1'b0, 40, 6, 7, "R1", "R3");
        test_mode(2'd2, 1'b0, 1'b1, 48, 5, 6, "R1", "R3");
        test_mode(2'd0, 1'b1, 1'b0, 256, 1, 1, "R4", "R4");
        test_mode(2'd2, 1'b1, 1'b1, 256, 1, 1, "R4", "R4");
        test_midframe_change();
        test_power_down();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule